// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block is a combinational 32-bit operand shifter for the second operand of a RISC-style integer datapath. Each cycle it takes a value, one of four shift kinds, a shift amount and the current carry flag. It returns the shifted value and the carry-out that the flag logic uses. The shift kinds are logical left, logical right, arithmetic right and rotate right.

A mode input chooses where the amount comes from. In immediate mode the amount is a 5-bit field, and a zero in that field stands for special encodings: a shift by the full width, or a one-place rotate through the carry flag. In register mode the amount is the low byte of a register, from 0 to 255. Amounts of 32 or more saturate, with exact carry-out rules for each kind. A parameter can add an output register. By default the results are available in the same cycle as the inputs.

Top module: `opnd_shifter`

## Requirements
- R1: Kind codes are `kind_i` 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. In immediate mode (`reg_mode_i`=0) with n = `amt_i[4:0]` nonzero, the result is the value shifted or rotated by n. The carry-out is input bit 32-n for a left shift and input bit n-1 for the other three kinds.
- R2: In immediate mode, a logical left shift with n = 0 returns the value unchanged, and the carry-out equals `carry_i`.
- R3: In immediate mode, a logical right shift with n = 0 acts as a shift by 32. The result is zero and the carry-out is input bit 31.
- R4: In immediate mode, an arithmetic right shift with n = 0 acts as a shift by 32. Every result bit and the carry-out equal input bit 31.
- R5: In immediate mode, a rotate with n = 0 rotates one place right through the carry. The result is {`carry_i`, value[31:1]} and the carry-out is input bit 0.
- R6: In immediate mode, `amt_i[7:5]` has no effect on the result or the carry-out.
- R7: In register mode (`reg_mode_i`=1), an amount of 0 returns the value unchanged for every kind, and the carry-out equals `carry_i`.
- R8: In register mode, amounts from 1 to 31 give the same result and carry-out as immediate mode with the same nonzero amount.
- R9: In register mode, logical shifts by 32 or more give a zero result. The carry-out is input bit 0 for a left shift by exactly 32 and input bit 31 for a right shift by exactly 32. For larger amounts the carry-out is 0.
- R10: In register mode, an arithmetic right shift by 32 or more sets every result bit and the carry-out to input bit 31.
- R11: In register mode, a rotate uses only `amt_i[4:0]`. A nonzero amount whose low five bits are zero returns the value unchanged, with input bit 31 as the carry-out.
- R12: With the default parameters (no output register), `res_o` and `carry_o` follow the inputs in the same cycle. After reset, all-zero inputs give a zero result and a zero carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the optional output register |
| rst_n | input | 1 | Active-low reset of the optional output register |
| val_i | input | 32 | Value to shift |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_i | input | 8 | Shift amount; immediate mode reads bits [4:0] only |
| reg_mode_i | input | 1 | 0 = immediate amount, 1 = register amount |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench drives every kind in both modes with the amounts 0, 1, 31, 32, 33 and 255, using values whose top and bottom bits differ, with the carry flag both clear and set, and then adds random cases. It checks each result against an independent model. A design that treated an immediate zero as a plain zero shift would return the value unchanged for a right shift instead of zero or sign fill, and would drop the carry through the rotate. A design that clamped register amounts without telling exactly 32 from more than 32 would report the wrong carry-out at 33 and 255. A design that masked a register rotate of 32 to nothing would copy `carry_i` into the carry-out instead of bit 31. Driving immediate amounts with the upper bits set catches a design that lets those bits leak into the amount.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     val_i,
  input  logic [1:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             reg_mode_i,
  input  logic             carry_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);
  localparam int SW = $clog2(W);
  localparam logic [1:0] K_LSL = 2'd0;
  localparam logic [1:0] K_LSR = 2'd1;
  localparam logic [1:0] K_ASR = 2'd2;
  localparam logic [1:0] K_ROR = 2'd3;

  logic [SW-1:0] n_imm;
  logic          imm_zero, reg_zero, reg_ge, reg_big;
  logic [SW:0]   s_lin;
  logic [SW-1:0] s_rot;
  logic [W-1:0]  fill;
  logic [W:0]    lsl_x;
  logic [2*W:0]  rsh_x;
  logic [2*W-1:0] rot_x;
  logic [W-1:0]  res_n;
  logic          c_n;

  assign n_imm    = amt_i[SW-1:0];
  assign imm_zero = (n_imm == '0);
  assign reg_zero = (amt_i == '0);
  assign reg_ge   = (amt_i >= AMT_W'(W));
  assign reg_big  = (amt_i >  AMT_W'(W));

  // Linear shift distance, saturated at W; an immediate zero means W.
  always_comb begin
    if (reg_mode_i)
      s_lin = reg_ge ? (SW+1)'(W) : {1'b0, amt_i[SW-1:0]};
    else
      s_lin = imm_zero ? (SW+1)'(W) : {1'b0, n_imm};
  end

  assign s_rot = amt_i[SW-1:0];
  assign fill  = (kind_i == K_ASR) ? {W{val_i[W-1]}} : '0;
  assign lsl_x = {1'b0, val_i} << s_lin;
  assign rsh_x = {fill, val_i, 1'b0} >> s_lin;
  assign rot_x = {val_i, val_i} >> s_rot;

  always_comb begin
    res_n = val_i;
    c_n   = carry_i;
    if (reg_mode_i ? !reg_zero : !(imm_zero && kind_i == K_LSL)) begin
      unique case (kind_i)
        K_LSL: begin
          res_n = lsl_x[W-1:0];
          c_n   = lsl_x[W] & ~(reg_mode_i & reg_big);
        end
        K_LSR: begin
          res_n = rsh_x[W:1];
          c_n   = rsh_x[0] & ~(reg_mode_i & reg_big);
        end
        K_ASR: begin
          res_n = rsh_x[W:1];
          c_n   = rsh_x[0];
        end
        default: begin
          if (!reg_mode_i && imm_zero) begin
            res_n = {carry_i, val_i[W-1:1]};
            c_n   = val_i[0];
          end else begin
            res_n = rot_x[W-1:0];
            c_n   = rot_x[W-1];
          end
        end
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_o   <= '0;
          carry_o <= 1'b0;
        end else begin
          res_o   <= res_n;
          carry_o <= c_n;
        end
      end
    end else begin : g_comb
      assign res_o   = res_n;
      assign carry_o = c_n;
    end
  endgenerate
endmodule

module opnd_shifter_chk #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     val_i,
  input logic [1:0]       kind_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             reg_mode_i,
  input logic             carry_i,
  input logic [W-1:0]     res_o,
  input logic             carry_o
);
  localparam int SW = $clog2(W);

  logic [W-1:0]     v;
  logic [1:0]       k;
  logic [AMT_W-1:0] a;
  logic             rm, c, live;

  generate
    if (REG_OUT) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v <= '0; k <= '0; a <= '0; rm <= 1'b0; c <= 1'b0; live <= 1'b0;
        end else begin
          v <= val_i; k <= kind_i; a <= amt_i; rm <= reg_mode_i; c <= carry_i; live <= 1'b1;
        end
      end
    end else begin : g_now
      assign v = val_i;
      assign k = kind_i;
      assign a = amt_i;
      assign rm = reg_mode_i;
      assign c = carry_i;
      assign live = 1'b1;
    end
  endgenerate

  // R7
  reg_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rm && a == '0) |-> (res_o == v && carry_o == c));

  // R3
  imm_lsr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rm && k == 2'd1 && a[SW-1:0] == '0) |-> (res_o == '0 && carry_o == v[W-1]));

  // R5
  imm_rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rm && k == 2'd3 && a[SW-1:0] == '0) |-> (res_o == {c, v[W-1:1]} && carry_o == v[0]));

  // R9
  reg_far_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rm && !k[1] && a > AMT_W'(W)) |-> (res_o == '0 && !carry_o));

  // R10
  reg_asr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rm && k == 2'd2 && a >= AMT_W'(W)) |-> (res_o == {W{v[W-1]}} && carry_o == v[W-1]));

  // R11
  reg_rot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rm && k == 2'd3 && a != '0 && a[SW-1:0] == '0) |-> (res_o == v && carry_o == v[W-1]));
endmodule

bind opnd_shifter opnd_shifter_chk #(.W(W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] val_i = '0;
  logic [1:0]  kind_i = '0;
  logic [7:0]  amt_i = '0;
  logic        reg_mode_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] res_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] q_res[$];
  logic        q_c[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  opnd_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .val_i(val_i), .kind_i(kind_i), .amt_i(amt_i),
    .reg_mode_i(reg_mode_i), .carry_i(carry_i), .res_o(res_o), .carry_o(carry_o)
  );

  function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] k,
                                        input logic [7:0] a, input logic rm, input logic c);
    int n;
    logic [31:0] r;
    logic co;
    r = v; co = c;
    if (!rm) begin
      n = int'(a[4:0]);
      if (n == 0) begin
        case (k)
          2'd0: begin r = v; co = c; end
          2'd1: begin r = 32'd0; co = v[31]; end
          2'd2: begin r = {32{v[31]}}; co = v[31]; end
          default: begin r = {c, v[31:1]}; co = v[0]; end
        endcase
      end
    end else begin
      n = int'(a);
      if (n != 0) begin
        case (k)
          2'd0: if (n < 32) begin r = v << n; co = v[32-n]; end
                else begin r = 32'd0; co = (n == 32) ? v[0] : 1'b0; end
          2'd1: if (n < 32) begin r = v >> n; co = v[n-1]; end
                else begin r = 32'd0; co = (n == 32) ? v[31] : 1'b0; end
          2'd2: if (n < 32) begin r = 32'($signed(v) >>> n); co = v[n-1]; end
                else begin r = {32{v[31]}}; co = v[31]; end
          default: begin
            n = n % 32;
            if (n == 0) begin r = v; co = v[31]; end
            else begin r = (v >> n) | (v << (32 - n)); co = v[n-1]; end
          end
        endcase
        return {co, r};
      end
      return {c, v};
    end
    if (n != 0) begin
      case (k)
        2'd0: begin r = v << n; co = v[32-n]; end
        2'd1: begin r = v >> n; co = v[n-1]; end
        2'd2: begin r = 32'($signed(v) >>> n); co = v[n-1]; end
        default: begin r = (v >> n) | (v << (32 - n)); co = v[n-1]; end
      endcase
    end
    return {co, r};
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic [7:0] a, input logic rm);
    if (!rm) begin
      if (a[7:5] != 3'd0) return "R6";
      if (a[4:0] != 5'd0) return "R1";
      case (k)
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (a == 8'd0) return "R7";
    if (k == 2'd3) return (a[4:0] == 5'd0) ? "R11" : ((a < 8'd32) ? "R8" : "R11");
    if (a < 8'd32) return "R8";
    return (k == 2'd2) ? "R10" : "R9";
  endfunction

  task automatic drive(input logic [31:0] v, input logic [1:0] k, input logic [7:0] a,
                       input logic rm, input logic c);
    logic [32:0] e;
    @(negedge clk);
    val_i = v; kind_i = k; amt_i = a; reg_mode_i = rm; carry_i = c;
    e = model(v, k, a, rm, c);
    q_res.push_back(e[31:0]);
    q_c.push_back(e[32]);
    q_tag.push_back(tag_of(k, a, rm));
  endtask

  initial begin : monitor
    logic [31:0] er;
    logic ec;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (q_res.size() > 0) begin
        er = q_res.pop_front();
        ec = q_c.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (res_o !== er || carry_o !== ec) begin
          errors++;
          $display("FAIL %s: res=%h carry=%b expected res=%h carry=%b", t, res_o, carry_o, er, ec);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    logic [31:0] vals[3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state with all-zero inputs (also R2: immediate left by zero)
    checks++;
    if (res_o !== 32'd0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R12: res=%h carry=%b expected res=00000000 carry=0", res_o, carry_o);
    end
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 2; m++)
        for (int ai = 0; ai < 6; ai++)
          for (int vi = 0; vi < 3; vi++)
            for (int c = 0; c < 2; c++)
              drive(vals[vi], 2'(k), 8'(amts[ai]), m[0], c[0]);
    // R6 upper immediate bits with zero low bits, R11 rotate wrap by 64
    for (int k = 0; k < 4; k++) begin
      drive(32'hC000_0003, 2'(k), 8'hE0, 1'b0, 1'b1);
      drive(32'h4000_0002, 2'(k), 8'hA7, 1'b0, 1'b0);
    end
    drive(32'h8765_4321, 2'd3, 8'd64, 1'b1, 1'b0);
    drive(32'h1234_5678, 2'd3, 8'd96, 1'b1, 1'b1);
    // R1 R8 random coverage
    for (int i = 0; i < 500; i++)
      drive($urandom, 2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    while (q_res.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule